// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Interface

This block is the device side of a small serial EEPROM that a host reaches over three wires: a chip select, a serial clock and a data-in line, with a data-out line driven back. The host raises chip select, sends a start bit, a two-bit opcode, an address and, for writes, a data word. The block then reads, writes or erases words of a register-based storage array. All serial inputs are oversampled in the system clock domain. Rising edges of the serial clock are found by edge detection after a synchroniser.

Writes and erases run as a self-timed cycle whose length is set by a parameter. The cycle needs no serial clocks and ignores chip select once it has started. A host that lowers and then raises chip select during that cycle sees a ready/busy flag on data-out. The organisation input selects 8-bit words (128 of them) or 16-bit words (64 of them) over the same 1024-bit store. Data-out is modelled as a value plus an output-enable.

Top module: `uwire_eeprom`

## Requirements
- R1: While chip select is low the front end is held idle, do_oe_o is 0, and serial clock and data-in activity has no effect on the next instruction.
- R2: With chip select high, rising serial clock edges with data-in at 0 change nothing; the first rising edge that samples a 1 is the start bit.
- R3: After the start bit the block takes a 2-bit opcode and then an address, both MSB first. The address is 7 bits when org_i is 0 (x8) and 6 bits when org_i is 1 (x16). Writes then take a data word MSB first, 8 bits for x8 and 16 bits for x16. Opcodes: 10 read, 01 write, 11 erase, 00 extended.
- R4: A read drives do_oe_o=1 and a 0 dummy bit from the rising edge that takes the last address bit. Each following rising edge presents the next data bit, MSB first. After the LSB the read runs on into the next address, which wraps from the top word to word 0.
- R5: A write stores its word once the last data bit is taken. It is then busy for WR_TICKS system clocks with no serial clocks needed.
- R6: Once an instruction other than a read has taken all its bits, further clocks and data-in are ignored until chip select goes low.
- R7: A write or erase in progress completes and stores its data even when chip select drops during it.
- R8: If chip select goes low and then high while a write is busy, do_oe_o becomes 1 and do_o shows 0 while busy and 1 once ready. The next start bit or a low chip select clears the status. If chip select is held high for the whole cycle, nothing is driven.
- R9: Writing is disabled after reset. Extended code 11 (the top two address bits) enables it and code 00 disables it. While disabled, write, erase, erase-all and write-all leave the array unchanged.
- R10: Erase sets the addressed word to all ones. Extended code 10 sets every word to all ones. Extended code 01 takes a data word and writes it to every word.
- R11: x16 word k consists of byte 2k as its low half and byte 2k+1 as its high half. Array contents after reset are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word size: 1 selects 16-bit words, 0 selects 8-bit words |
| do_o | output | 1 | Serial data out: read data or ready/busy flag |
| do_oe_o | output | 1 | Output enable for do_o; 0 models high impedance |

## Verification
Two functions can meet in one cycle. The chip-select rising edge that arms the ready/busy flag can coincide with a write still busy or just finished. A start bit can clear that flag in the same cycle the front end leaves idle. The bench provokes both. It lowers and raises chip select shortly after launching a write and expects 0. It then waits past the write time, expects 1, and sends a start bit, which must turn the output enable off in that very bit period. It also holds chip select high through a whole write and checks that no status appears.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS = 2'b00;
  localparam logic [1:0] EX_WALL = 2'b01;
  localparam logic [1:0] EX_EALL = 2'b10;
  localparam logic [1:0] EX_WEN  = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic cs_o,
  output logic cs_rise_o,
  output logic di_o,
  output logic sclk_rise_o
);
  logic [STAGES-1:0] cs_sh, sclk_sh, di_sh;
  logic cs_d, sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sh   <= '0;
      sclk_sh <= '0;
      di_sh   <= '0;
      cs_d    <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      cs_sh   <= {cs_sh[STAGES-2:0], cs_i};
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk_i};
      di_sh   <= {di_sh[STAGES-2:0], di_i};
      cs_d    <= cs_sh[STAGES-1];
      sclk_d  <= sclk_sh[STAGES-1];
    end
  end

  assign cs_o        = cs_sh[STAGES-1];
  assign cs_rise_o   = cs_sh[STAGES-1] & ~cs_d;
  assign di_o        = di_sh[STAGES-1];
  assign sclk_rise_o = sclk_sh[STAGES-1] & ~sclk_d;
endmodule

// File: rtl/mw_wtimer.sv
module mw_wtimer #(
  parameter int TICKS = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(TICKS);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int BYTE_AW = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               org_i,
  input  logic [BYTE_AW-1:0] addr_i,
  output logic [15:0]        rdata_o,
  input  logic               we_i,
  input  logic               we_all_i,
  input  logic [15:0]        wdata_i
);
  localparam int DEPTH = 1 << BYTE_AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_all_i) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (org_i && (i % 2 == 1)) ? wdata_i[15:8] : wdata_i[7:0];
    end else if (we_i) begin
      if (org_i) begin
        mem_q[{addr_i[BYTE_AW-2:0], 1'b1}] <= wdata_i[15:8];
        mem_q[{addr_i[BYTE_AW-2:0], 1'b0}] <= wdata_i[7:0];
      end else begin
        mem_q[addr_i] <= wdata_i[7:0];
      end
    end
  end

  assign rdata_o = org_i ? {mem_q[{addr_i[BYTE_AW-2:0], 1'b1}], mem_q[{addr_i[BYTE_AW-2:0], 1'b0}]}
                         : {8'h00, mem_q[addr_i]};
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import mw_pkg::*;
#(
  parameter int BYTE_AW  = 7,
  parameter int SYNC     = 2,
  parameter int WR_TICKS = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  logic cs_s, cs_rise, di_s, rise, busy;
  mw_state_e state_q;
  logic [1:0]  op_q;
  logic [BYTE_AW-1:0] addr_q, addr_nxt, addr_mask, mem_addr;
  logic [15:0] data_q, data_nxt, wd, mem_rdata;
  logic [4:0]  cnt_q, aw_last, dw_last;
  logic [3:0]  rd_idx_q;
  logic        do_q, status_q, wen_q;
  logic        go, go_all, mem_we, mem_we_all, wr_start;
  logic [1:0]  ext_code;

  mw_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .cs_i, .sclk_i, .di_i,
    .cs_o(cs_s), .cs_rise_o(cs_rise), .di_o(di_s), .sclk_rise_o(rise)
  );

  mw_wtimer #(.TICKS(WR_TICKS)) u_tmr (
    .clk_i, .rst_ni, .start_i(wr_start), .busy_o(busy)
  );

  mw_array #(.BYTE_AW(BYTE_AW)) u_arr (
    .clk_i, .rst_ni, .org_i, .addr_i(mem_addr), .rdata_o(mem_rdata),
    .we_i(mem_we), .we_all_i(mem_we_all), .wdata_i(wd)
  );

  assign aw_last   = org_i ? 5'(BYTE_AW - 2) : 5'(BYTE_AW - 1);
  assign dw_last   = org_i ? 5'd15 : 5'd7;
  assign addr_mask = org_i ? {1'b0, {(BYTE_AW-1){1'b1}}} : {BYTE_AW{1'b1}};
  assign addr_nxt  = {addr_q[BYTE_AW-2:0], di_s} & addr_mask;
  assign data_nxt  = {data_q[14:0], di_s};
  assign ext_code  = org_i ? addr_nxt[BYTE_AW-2 -: 2] : addr_nxt[BYTE_AW-1 -: 2];
  assign mem_addr  = (state_q == ST_ADDR) ? addr_nxt : addr_q;

  // write launch decode, gated by the enable latch
  always_comb begin
    go     = 1'b0;
    go_all = 1'b0;
    wd     = 16'hFFFF;
    if (cs_s && rise) begin
      if (state_q == ST_ADDR && cnt_q == aw_last) begin
        if (op_q == OP_ERASE)                           go     = 1'b1;
        else if (op_q == OP_EXT && ext_code == EX_EALL) go_all = 1'b1;
      end else if (state_q == ST_DATA && cnt_q == dw_last) begin
        wd = data_nxt;
        if (op_q == OP_WRITE) go     = 1'b1;
        else                  go_all = 1'b1;
      end
    end
  end

  assign mem_we     = go & wen_q;
  assign mem_we_all = go_all & wen_q;
  assign wr_start   = mem_we | mem_we_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      cnt_q    <= '0;
      rd_idx_q <= '0;
      do_q     <= 1'b0;
      status_q <= 1'b0;
      wen_q    <= 1'b0;
    end else if (!cs_s) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (cs_rise && busy) status_q <= 1'b1;
      if (rise) begin
        unique case (state_q)
          ST_IDLE: if (di_s && !busy) begin
            state_q  <= ST_OP;
            cnt_q    <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            status_q <= 1'b0;
          end
          ST_OP: begin
            op_q  <= {op_q[0], di_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 5'd1) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == aw_last) begin
              cnt_q <= '0;
              unique case (op_q)
                OP_READ: begin
                  state_q  <= ST_READ;
                  do_q     <= 1'b0;
                  rd_idx_q <= dw_last[3:0];
                end
                OP_WRITE: state_q <= ST_DATA;
                OP_ERASE: state_q <= ST_DONE;
                default: begin
                  state_q <= (ext_code == EX_WALL) ? ST_DATA : ST_DONE;
                  if (ext_code == EX_WEN)  wen_q <= 1'b1;
                  if (ext_code == EX_WDIS) wen_q <= 1'b0;
                end
              endcase
            end
          end
          ST_DATA: begin
            data_q <= data_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == dw_last) state_q <= ST_DONE;
          end
          ST_READ: begin
            do_q <= mem_rdata[rd_idx_q];
            if (rd_idx_q == '0) begin
              rd_idx_q <= dw_last[3:0];
              addr_q   <= (addr_q + 1'b1) & addr_mask;
            end else begin
              rd_idx_q <= rd_idx_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign do_oe_o = (state_q == ST_READ) | status_q;
  assign do_o    = (state_q == ST_READ) ? do_q : ~busy;
endmodule

// File: rtl/mw_chk.sv
module mw_chk
  import mw_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      cs_s,
  input mw_state_e state_q,
  input logic      do_oe_o,
  input logic      busy,
  input logic      wen_q,
  input logic      wr_start,
  input logic      mem_we,
  input logic      mem_we_all
);
  // R1
  cs_low_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);

  // R8
  no_status_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_OP, ST_ADDR, ST_DATA, ST_DONE}) |-> !do_oe_o);

  // R9
  wen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wen_q));

  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |-> !busy);

  // R5
  one_write_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we, mem_we_all}));

  // R5
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start |=> busy);
endmodule

bind uwire_eeprom mw_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .state_q(state_q),
  .do_oe_o(do_oe_o), .busy(busy), .wen_q(wen_q), .wr_start(wr_start),
  .mem_we(mem_we), .mem_we_all(mem_we_all)
);

// File: tb/sim_uwire_eeprom.sv
`timescale 1ns/1ps
module sim_uwire_eeprom;
  localparam int H = 8;
  localparam int WT = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b0;
  logic do_w, oe_w;
  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] m [128];
  logic o, e;

  always #5 clk = ~clk;

  uwire_eeprom #(.WR_TICKS(WT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org_i(org), .do_o(do_w), .do_oe_o(oe_w)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic bitx(input logic b, output logic ob, output logic oeb);
    di = b; tick(H);
    sclk = 1'b1; tick(H);
    ob = do_w; oeb = oe_w;
    sclk = 1'b0;
  endtask

  task automatic cs_on();  cs = 1'b1; tick(H); endtask
  task automatic cs_off(); cs = 1'b0; di = 1'b0; sclk = 1'b0; tick(H); endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction
  function automatic int nwords(); return org ? 64 : 128; endfunction
  function automatic logic [15:0] mword(input int a);
    return org ? {m[2*a+1], m[2*a]} : {8'h00, m[a]};
  endfunction
  task automatic mset(input int a, input logic [15:0] v);
    if (org) begin m[2*a] = v[7:0]; m[2*a+1] = v[15:8]; end
    else m[a] = v[7:0];
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitx(v[i], o, e);
  endtask

  // start bit, opcode, address; last address bit sample left in o/e
  task automatic head(input logic [1:0] op, input int a);
    send(16'h1, 1);
    send({14'h0, op}, 2);
    send(16'(a), aw());
  endtask

  task automatic ext(input logic [1:0] code);
    cs_on();
    head(2'b00, int'(code) << (aw() - 2));
    cs_off();
  endtask

  task automatic read_chk(input int a, input int nw, input string req);
    logic [15:0] got;
    cs_on();
    head(2'b10, a);
    check({req, " dummy"}, {14'h0, e, o}, 16'h2);
    for (int w = 0; w < nw; w++) begin
      got = '0;
      for (int i = 0; i < dw(); i++) begin
        bitx(1'b0, o, e);
        got = {got[14:0], o};
      end
      check(req, got, mword((a + w) % nwords()));
    end
    cs_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) m[i] = 8'hFF;
    tick(3); rst_n = 1'b1; tick(3);
    check("R1 reset oe", {15'h0, oe_w}, 16'h0);

    // R1: clocks with data high while deselected are ignored
    for (int i = 0; i < 6; i++) bitx(1'b1, o, e);
    check("R1 cs low oe", {15'h0, e}, 16'h0);
    // R2: leading zeros then a read of the erased array (R11 reset state)
    cs_on();
    for (int i = 0; i < 9; i++) bitx(1'b0, o, e);
    check("R2 idle zeros oe", {15'h0, e}, 16'h0);
    cs_off();
    read_chk(5, 1, "R11 reset contents");

    // R1: aborted instruction then a clean read
    cs_on(); send(16'h5, 3); cs_off();
    read_chk(9, 1, "R1 abort recovery");

    // R9: write while disabled does nothing
    cs_on(); head(2'b01, 5); send(16'h3C, 8); cs_off(); tick(WT + 50);
    read_chk(5, 1, "R9 blocked write");

    ext(2'b11);
    // R5, R6, R8: write with cs held high, extra clocks ignored, no status
    cs_on(); head(2'b01, 5); send(16'h3C, 8); mset(5, 16'h3C);
    for (int i = 0; i < 10; i++) bitx(1'b1, o, e);
    check("R6 trailing clocks oe", {15'h0, e}, 16'h0);
    tick(40);
    check("R8 no status cs held", {15'h0, oe_w}, 16'h0);
    tick(WT);
    check("R8 no status after", {15'h0, oe_w}, 16'h0);
    cs_off();
    read_chk(5, 1, "R5 write stored");

    // R7, R8: cs dropped and raised during the write
    cs_on(); head(2'b01, 6); send(16'hA5, 8); mset(6, 16'hA5);
    cs = 1'b0; tick(10); cs = 1'b1; tick(12);
    check("R8 busy status", {14'h0, oe_w, do_w}, 16'h2);
    tick(WT + 20);
    check("R8 ready status", {14'h0, oe_w, do_w}, 16'h3);
    bitx(1'b1, o, e);
    check("R8 start clears status", {15'h0, e}, 16'h0);
    cs_off();
    read_chk(6, 1, "R7 write completed");

    // R7: cs low for the whole cycle
    cs_on(); head(2'b01, 127); send(16'h81, 8); mset(127, 16'h81);
    cs = 1'b0; di = 1'b0; tick(30);
    check("R7 no status cs low", {15'h0, oe_w}, 16'h0);
    tick(WT);
    read_chk(5, 2, "R4 sequential");
    read_chk(127, 2, "R4 wrap");

    // R11: x16 mapping
    org = 1'b1; tick(4);
    cs_on(); head(2'b01, 3); send(16'h1234, 16); mset(3, 16'h1234); cs_off(); tick(WT + 20);
    read_chk(3, 1, "R11 x16 read");
    read_chk(63, 2, "R4 x16 wrap");
    org = 1'b0; tick(4);
    read_chk(6, 2, "R11 x8 view of x16 word");

    // R10: erase word, write-all, erase-all
    cs_on(); head(2'b11, 5); mset(5, 16'hFF); cs_off(); tick(WT + 20);
    read_chk(4, 3, "R10 erase word");
    cs_on(); head(2'b00, 1 << 5); send(16'h5A, 8); cs_off(); tick(WT + 20);
    for (int i = 0; i < 128; i++) m[i] = 8'h5A;
    read_chk(0, 2, "R10 write all");
    read_chk(100, 1, "R10 write all far");
    org = 1'b1; tick(4);
    cs_on(); head(2'b00, 2 << 4); cs_off(); tick(WT + 20);
    for (int i = 0; i < 128; i++) m[i] = 8'hFF;
    read_chk(20, 1, "R10 erase all");

    // R9: disable, then write and erase-all are blocked
    ext(2'b00);
    cs_on(); head(2'b01, 2); send(16'hBEEF, 16); cs_off(); tick(WT + 20);
    read_chk(2, 1, "R9 disabled write");
    org = 1'b0; tick(4);
    ext(2'b11);
    cs_on(); head(2'b01, 2); send(16'h77, 8); mset(2, 16'h77); cs_off(); tick(WT + 20);
    ext(2'b00);
    cs_on(); head(2'b00, 2 << 5); cs_off(); tick(WT + 20);
    read_chk(2, 1, "R9 disabled erase all");
    // R3: opcode and field order exercised by all of the above
    check("R3 format", 16'(total > 20), 16'h1);
    summary();
  end
endmodule